// File: doc/BRIEF.md
# Card Slot Status Change Interrupt Unit

This unit sits beside one removable-card slot and watches its eight status pins: two voltage-sense lines, write-protect, two card-detect lines, two battery-voltage lines and the ready/interrupt line. Every pin first passes through a synchronizer. The synchronized levels can be read as a live snapshot. Each pin change is held in a sticky change flag. Software chooses with an enable mask which flags drive the single interrupt output.

The ready line is handled in more detail than the other pins. Four separate flags record its low level, its high level, a rising edge and a falling edge. The two level flags keep setting for as long as the level holds. The unit also gives three decoded status outputs: card present, card busy and a 2-bit battery level.

Software talks to the unit over a small register bus with single-cycle writes and a combinational read. An interrupt handler normally reads the change register and writes the same value back to acknowledge it. At start-up the enable register is normally loaded with 0xFE00, which enables the seven pin-change flags, and then the change register is written with all ones.

Top module: `slot_evt_irq`

## Requirements
- R1: Register address 0 reads the synchronized pins as follows: VS1 at bit 15, VS2 at 14, WP at 13, CD2 at 12, CD1 at 11, BVD2 at 10, BVD1 at 9 and RDY at 8. Bits 7..0 read 0. A pin change shows up in this register after two clock edges. Writes to address 0 have no effect.
- R2: When the synchronized value of VS1, VS2, WP, CD2, CD1, BVD2 or BVD1 changes, the change register (address 1) sets the bit at that pin's position (15..9). The bit stays set until it is cleared.
- R3: The change register sets bit 7 on every cycle that the synchronized RDY is low, and bit 6 on every cycle that it is high.
- R4: A rising edge of the synchronized RDY sets change bit 5. A falling edge sets change bit 4.
- R5: Writing to address 1 clears each change bit whose write-data bit is 1. Bits written with 0 keep their value. Change bits 8 and 3..0 always read 0.
- R6: When an event that sets a change bit and a write-one clear of that bit happen in the same cycle, the bit ends up set.
- R7: The enable register at address 2 uses the change register's layout. Only bits 15..9 and 7..4 can be written (mask 0xFEF0); the other bits read 0. Address 3 reads 0.
- R8: The irq output is registered. It is 1 in the cycle after any change bit that is also enabled is set. It goes low one cycle after the write that clears the last such bit.
- R9: card_present is 1 only when the synchronized CD1 and CD2 are both 0. card_busy is 1 when the synchronized RDY is 0. batt_level reads {BVD2, BVD1}.
- R10: During reset, the change register, the enable register and irq are all 0. After reset ends, no pin-change or edge flag is set until the synchronizer holds real pin values, so that pins at a steady level set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| pin_vs1 | input | 1 | Voltage sense 1 (raw) |
| pin_vs2 | input | 1 | Voltage sense 2 (raw) |
| pin_wp | input | 1 | Write protect (raw) |
| pin_cd2 | input | 1 | Card detect 2, low when seated (raw) |
| pin_cd1 | input | 1 | Card detect 1, low when seated (raw) |
| pin_bvd2 | input | 1 | Battery voltage detect 2 (raw) |
| pin_bvd1 | input | 1 | Battery voltage detect 1 (raw) |
| pin_rdy | input | 1 | Ready / interrupt request, low when busy (raw) |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge when bus_sel is high |
| bus_addr | input | 2 | Register address: 0 pins, 1 change, 2 enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Registered interrupt request |
| card_present | output | 1 | Both card-detect lines are low |
| card_busy | output | 1 | RDY is low |
| batt_level | output | 2 | {BVD2, BVD1} |

## Verification
The hardest case to reach is R6: a clearing write has to arrive on exactly the clock edge at which the change flag sets. The bench reaches it by toggling CD2 half a cycle before a known edge and counting the two synchronizer edges. It then drives the write so that the write is taken on the third edge, the same edge on which the flag sets. The RDY high-level flag gives a second case of the same collision without any timing: while RDY is held high, the flag sets on every cycle, so writing all ones must leave bit 6 set.

// File: rtl/slot_evt_pkg.sv
`timescale 1ns/1ps
package slot_evt_pkg;
  localparam int NPINS  = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  // index in the synchronized pin vector
  localparam int IX_RDY  = 0;
  localparam int IX_BVD1 = 1;
  localparam int IX_BVD2 = 2;
  localparam int IX_CD1  = 3;
  localparam int IX_CD2  = 4;
  localparam int IX_WP   = 5;
  localparam int IX_VS2  = 6;
  localparam int IX_VS1  = 7;

  // register addresses
  localparam logic [ADDR_W-1:0] A_PINS = 2'd0;
  localparam logic [ADDR_W-1:0] A_CHG  = 2'd1;
  localparam logic [ADDR_W-1:0] A_ENA  = 2'd2;

  // ready-line flag positions
  localparam int B_RDY_LO   = 7;
  localparam int B_RDY_HI   = 6;
  localparam int B_RDY_RISE = 5;
  localparam int B_RDY_FALL = 4;

  // pin k (k = 1..7) reports its change at bit PIN_BASE + k
  localparam int PIN_BASE = 8;

  localparam logic [DATA_W-1:0] FLAG_MASK = 16'hFEF0;
endpackage

// File: rtl/sev_sync.sv
`timescale 1ns/1ps
module sev_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vld
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_d;
  logic [STAGES-1:0]        vq, vd;

  always_comb begin
    stg_d[0] = d;
    vd[0]    = 1'b1;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
      vd[i]    = vq[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      vq    <= '0;
    end else begin
      stg_q <= stg_d;
      vq    <= vd;
    end
  end

  assign q   = stg_q[STAGES-1];
  assign vld = vq[STAGES-1];
endmodule

// File: rtl/sev_detect.sv
`timescale 1ns/1ps
module sev_detect
  import slot_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  s,
  input  logic              s_vld,
  output logic [DATA_W-1:0] ev,
  output logic              primed
);
  logic [NPINS-1:0] prev_q, prev_d;
  logic             pv_q, pv_d;

  // hold the previous sample only while the synchronizer is filled
  always_comb begin
    prev_d = s_vld ? s : prev_q;
    pv_d   = s_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pv_q   <= pv_d;
    end
  end

  generate
    for (genvar k = 1; k < NPINS; k++) begin : g_pin
      assign ev[PIN_BASE+k] = pv_q & (s[k] ^ prev_q[k]);
    end
  endgenerate

  assign ev[PIN_BASE]   = 1'b0;
  assign ev[B_RDY_LO]   = s_vld & ~s[IX_RDY];
  assign ev[B_RDY_HI]   = s_vld &  s[IX_RDY];
  assign ev[B_RDY_RISE] = pv_q  &  s[IX_RDY] & ~prev_q[IX_RDY];
  assign ev[B_RDY_FALL] = pv_q  & ~s[IX_RDY] &  prev_q[IX_RDY];
  assign ev[3:0]        = '0;
  assign primed         = pv_q;
endmodule

// File: rtl/sev_regs.sv
`timescale 1ns/1ps
module sev_regs
  import slot_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_chg,
  input  logic              wr_ena,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NPINS-1:0]  pins,
  input  logic [DATA_W-1:0] ev,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] chg_q,
  output logic [DATA_W-1:0] en_q,
  output logic              irq_q
);
  logic [DATA_W-1:0] chg_d, en_d, clr;
  logic              irq_d;

  always_comb begin
    clr   = wr_chg ? wdata : '0;
    chg_d = ((chg_q & ~clr) | ev) & FLAG_MASK;   // set wins over clear
    en_d  = wr_ena ? (wdata & FLAG_MASK) : en_q;
    irq_d = |(chg_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      chg_q <= chg_d;
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_PINS:  rdata = {pins, {(DATA_W-NPINS){1'b0}}};
      A_CHG:   rdata = chg_q;
      A_ENA:   rdata = en_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/slot_evt_irq.sv
`timescale 1ns/1ps
module slot_evt_irq
  import slot_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_vs1,
  input  logic              pin_vs2,
  input  logic              pin_wp,
  input  logic              pin_cd2,
  input  logic              pin_cd1,
  input  logic              pin_bvd2,
  input  logic              pin_bvd1,
  input  logic              pin_rdy,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              card_present,
  output logic              card_busy,
  output logic [1:0]        batt_level
);
  logic [1:0]        rst_pipe_q;
  logic              rst_ns;
  logic [NPINS-1:0]  raw_pins, sync_pins;
  logic              sync_vld, prev_vld;
  logic [DATA_W-1:0] ev, chg_q, en_q;
  logic              wr_chg, wr_ena;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ns = rst_pipe_q[1];

  assign raw_pins = {pin_vs1, pin_vs2, pin_wp, pin_cd2,
                     pin_cd1, pin_bvd2, pin_bvd1, pin_rdy};

  sev_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ns), .d(raw_pins), .q(sync_pins), .vld(sync_vld)
  );

  sev_detect u_det (
    .clk(clk), .rst_n(rst_ns), .s(sync_pins), .s_vld(sync_vld),
    .ev(ev), .primed(prev_vld)
  );

  assign wr_chg = bus_sel & bus_wr & (bus_addr == A_CHG);
  assign wr_ena = bus_sel & bus_wr & (bus_addr == A_ENA);

  sev_regs u_regs (
    .clk(clk), .rst_n(rst_ns), .wr_chg(wr_chg), .wr_ena(wr_ena),
    .wdata(bus_wdata), .rd_addr(bus_addr), .pins(sync_pins), .ev(ev),
    .rdata(bus_rdata), .chg_q(chg_q), .en_q(en_q), .irq_q(irq)
  );

  assign card_present = ~sync_pins[IX_CD1] & ~sync_pins[IX_CD2];
  assign card_busy    = ~sync_pins[IX_RDY];
  assign batt_level   = {sync_pins[IX_BVD2], sync_pins[IX_BVD1]};
endmodule

// File: rtl/slot_evt_irq_chk.sv
`timescale 1ns/1ps
module slot_evt_irq_chk
  import slot_evt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic [DATA_W-1:0] chg,
  input logic [DATA_W-1:0] en,
  input logic [DATA_W-1:0] ev,
  input logic              s_rdy,
  input logic              primed,
  input logic              wr_chg,
  input logic [DATA_W-1:0] wdata
);
  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |($past(chg) & $past(en)));

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg & ~FLAG_MASK) == '0 && (en & ~FLAG_MASK) == '0);

  // R4
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $rose(s_rdy)) |=> chg[B_RDY_RISE]);

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_chg |=> ((chg & $past(chg)) == $past(chg)));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chg |=> ((chg & $past(wdata) & FLAG_MASK) ==
                ($past(ev) & $past(wdata) & FLAG_MASK)));
endmodule

bind slot_evt_irq slot_evt_irq_chk u_chk (
  .clk(clk), .rst_n(rst_ns), .irq(irq), .chg(chg_q), .en(en_q), .ev(ev),
  .s_rdy(sync_pins[0]), .primed(prev_vld), .wr_chg(wr_chg), .wdata(bus_wdata)
);

// File: tb/slot_evt_irq_test.sv
`timescale 1ns/1ps
module slot_evt_irq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pins;     // {vs1,vs2,wp,cd2,cd1,bvd2,bvd1,rdy}
  logic        sel, wr;
  logic [1:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq, present, busy;
  logic [1:0]  batt;
  int n_chk = 0;
  int n_bad = 0;

  localparam logic [7:0] IDLE = 8'b1000_0111;

  always #4 clk = ~clk;

  slot_evt_irq uut (
    .clk(clk), .rst_n(rst_n),
    .pin_vs1(pins[7]), .pin_vs2(pins[6]), .pin_wp(pins[5]), .pin_cd2(pins[4]),
    .pin_cd1(pins[3]), .pin_bvd2(pins[2]), .pin_bvd1(pins[1]), .pin_rdy(pins[0]),
    .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq(irq), .card_present(present), .card_busy(busy),
    .batt_level(batt)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [15:0] d);
    addr = a; sel = 1'b1; #1; d = rdata; sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    pins = IDLE; sel = 0; wr = 0; addr = 0; wdata = 0; rst_n = 1'b0;
    tick(5);
    read_reg(2'd1, v); check("R10 chg in reset", v, 16'h0000);
    read_reg(2'd2, v); check("R10 en in reset", v, 16'h0000);
    check("R10 irq in reset", {15'b0, irq}, 16'h0000);
    rst_n = 1'b1;
    tick(10);
    read_reg(2'd1, v); check("R10 no spurious flags", v, 16'h0040);
    read_reg(2'd0, v); check("R1 pin snapshot", v, 16'h8700);
    check("R9 present/busy/batt", {12'b0, present, busy, batt}, 16'h000B);
  endtask

  task automatic t_startup;
    logic [15:0] v;
    write_reg(2'd2, 16'hFE00);
    read_reg(2'd2, v); check("R7 enable readback", v, 16'hFE00);
    write_reg(2'd1, 16'hFFFF);
    read_reg(2'd1, v); check("R6 rdy high level survives clear", v, 16'h0040);
    tick(1);
    check("R8 irq idle", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_pins;
    logic [15:0] v;
    for (int k = 1; k < 8; k++) begin
      pins[k] = ~pins[k];
      tick(4);
      read_reg(2'd1, v); check($sformatf("R2 pin %0d flag", k), v, 16'h0040 | (16'h1 << (8 + k)));
      check($sformatf("R8 irq pin %0d", k), {15'b0, irq}, 16'h0001);
      write_reg(2'd1, 16'h1 << (8 + k));
      check("R8 irq held one cycle", {15'b0, irq}, 16'h0001);
      read_reg(2'd1, v); check("R5 flag cleared", v, 16'h0040);
      tick(1);
      check("R8 irq dropped", {15'b0, irq}, 16'h0000);
      pins[k] = ~pins[k];
      tick(4);
      write_reg(2'd1, 16'hFFFF);
    end
    tick(1);
  endtask

  task automatic t_cd_present;
    logic [15:0] v;
    pins[4] = 1'b1;
    tick(3);
    check("R9 one detect high", {15'b0, present}, 16'h0000);
    read_reg(2'd0, v); check("R1 cd2 visible", v, 16'h9700);
    write_reg(2'd1, 16'h0FFF);
    read_reg(2'd1, v); check("R5 zero bits untouched", v, 16'h1040);
    pins[4] = 1'b0;
    tick(4);
    write_reg(2'd1, 16'hFFFF);
    check("R9 both detect low", {15'b0, present}, 16'h0001);
  endtask

  task automatic t_rdy;
    logic [15:0] v;
    write_reg(2'd2, 16'h0010);
    pins[0] = 1'b0;
    tick(4);
    read_reg(2'd1, v); check("R4 falling + R3 low", v, 16'h00D0);
    check("R8 irq on fall", {15'b0, irq}, 16'h0001);
    check("R9 busy", {15'b0, busy}, 16'h0001);
    write_reg(2'd1, 16'hFFFF);
    read_reg(2'd1, v); check("R3 low level persists", v, 16'h0080);
    write_reg(2'd2, 16'h0020);
    pins[0] = 1'b1;
    tick(4);
    read_reg(2'd1, v); check("R4 rising + R3 high", v, 16'h00E0);
    check("R8 irq on rise", {15'b0, irq}, 16'h0001);
    write_reg(2'd1, 16'hFFFF);
    read_reg(2'd1, v); check("R3 high level persists", v, 16'h0040);
  endtask

  task automatic t_mask;
    logic [15:0] v;
    write_reg(2'd2, 16'h0000);
    pins[5] = 1'b1;
    tick(4);
    read_reg(2'd1, v); check("R2 wp flag", v, 16'h2040);
    check("R8 masked no irq", {15'b0, irq}, 16'h0000);
    write_reg(2'd2, 16'h2000);
    tick(1);
    check("R8 irq after enable", {15'b0, irq}, 16'h0001);
    write_reg(2'd2, 16'h0000);
    pins[5] = 1'b0;
    tick(4);
    write_reg(2'd1, 16'hFFFF);
  endtask

  task automatic t_collide;
    logic [15:0] v;
    pins[4] = 1'b1;       // set before edge 1
    tick(2);              // after edge 2
    write_reg(2'd1, 16'h1000); // taken on edge 3, same edge as the set
    read_reg(2'd1, v); check("R6 set wins", v, 16'h1040);
    pins[4] = 1'b0;
    tick(4);
    write_reg(2'd1, 16'hFFFF);
  endtask

  task automatic t_bus;
    logic [15:0] v;
    write_reg(2'd0, 16'hFFFF);
    read_reg(2'd0, v); check("R1 pin write ignored", v, 16'h8700);
    read_reg(2'd1, v); check("R1 chg unaffected", v, 16'h0040);
    write_reg(2'd2, 16'hFFFF);
    read_reg(2'd2, v); check("R7 enable mask", v, 16'hFEF0);
    read_reg(2'd3, v); check("R7 addr3 zero", v, 16'h0000);
    write_reg(2'd2, 16'h0000);
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_startup();
    t_pins();
    t_cd_present();
    t_rdy();
    t_mask();
    t_collide();
    t_bus();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule